// File: doc/BRIEF.md
# Multi-PLL Phase Alignment Calibrator

This block brings the reference and feedback clocks of three PLLs into phase. Each PLL has a phase-detector meter. Over one measurement window the meter counts how often the reference edge was seen late (a one) and how often it was seen early (a zero). For each PLL the calibrator drives two 5-bit delay fields, one on the reference path and one on the feedback path. It steps a delay code into one of them, waits for the loop to settle, opens the meters, and then reads the two counts. From these it decides whether to step again or to stop.

The first measurement on a PLL fixes the direction. If the reference lags, the feedback path is delayed. If the reference leads, the reference path is delayed. After that, only that one path moves, one code step per round, until the signed count difference falls within a threshold. The three PLLs share one settle and measure timeline. A PLL that has finished keeps its setting while the others carry on. The run ends when all three have finished, or it ends with a failure when any code reaches 32.

Control and status are plain level pins. No data stream crosses the edge of the block, so there is no valid/ready handshake and no back-pressure. The meter counts are sampled in the last measurement cycle and must be stable in that cycle.

Top module: `pll_phase_cal`

## Requirements
- R1: After reset, busy, meter_en, cal_done, cal_fail, every pll_done bit, every delay field and every lane_dir field are 0.
- R2: A start pulse puts every lane back to its initial state with code 0 and its done bit at 0, and clears cal_done and cal_fail. busy is high from the next cycle on.
- R3: Each round runs in this order: one apply cycle, SETTLE_CYC settle cycles, MEAS_CYC cycles with meter_en high, and one check cycle with meter_en low. A run of R rounds raises cal_done or cal_fail exactly R*(SETTLE_CYC+MEAS_CYC+2) cycles after the start edge.
- R4: The signed difference is D = ones - zeros, and it never wraps. In its first evaluation a lane has both delay fields at 0:
  - if D > THRESH, lane_dir becomes 1 (feedback delayed) and the code increments;
  - if -D > THRESH, lane_dir becomes 2 (reference delayed) and the code increments;
  - otherwise the lane is done, with lane_dir 0.
- R5: With lane_dir 1, the apply cycle writes the code to the feedback field and 0 to the reference field. The lane is done once D <= THRESH; otherwise the code increments.
- R6: With lane_dir 2, the apply cycle writes the code to the reference field and 0 to the feedback field. The lane is done once -D <= THRESH; otherwise the code increments.
- R7: A lane that is done keeps its delay fields, lane_dir and done bit unchanged while other lanes continue.
- R8: When all lanes are done, cal_done rises and busy falls. cal_done stays high until the next start, and it is never high together with cal_fail.
- R9: If any code reaches 32 at a check while not all lanes are done, cal_fail rises and the run stops with cal_done low. The failing lane's field keeps the last applied code, 31.
- R10: For any lane, at most one of the two delay fields is nonzero. The delay fields never change on an edge that follows a cycle with meter_en high, unless start is high in that cycle.
- R11: A start pulse during a run abandons that run and begins a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins (or restarts) calibration |
| ones_cnt | input | NUM_PLL*CNT_W | Per-lane meter count of ones; lane k at [k*CNT_W +: CNT_W] |
| zeros_cnt | input | NUM_PLL*CNT_W | Per-lane meter count of zeros; same packing |
| meter_en | output | 1 | Meter enable, high during the measure window |
| ref_dly | output | NUM_PLL*DLY_W | Per-lane reference-path delay field |
| fb_dly | output | NUM_PLL*DLY_W | Per-lane feedback-path delay field |
| lane_dir | output | NUM_PLL*2 | Per-lane direction: 0 initial, 1 feedback delayed, 2 reference delayed |
| pll_done | output | NUM_PLL | Per-lane done bit |
| busy | output | 1 | Calibration run in progress |
| cal_done | output | 1 | All lanes aligned; held until next start |
| cal_fail | output | 1 | A delay code reached 32 |

## Verification
The hardest case to bring about is a run where the lanes finish in different rounds: one lane stops early, another walks many codes, and a third heads for overflow. The frozen-lane rule and the failure ordering only show up in such runs. The bench closes the loop to get there. It computes each lane's meter counts from the delay fields the block itself drives, using a per-lane offset and gain. Directed offsets place a lane exactly on the threshold, one step past it, and beyond code 31. Random offsets and gains mix lanes that finish in different rounds, and a restart in the middle of a run is issued as well.

// File: rtl/pcal_pkg.sv
package pcal_pkg;
  typedef enum logic [1:0] {
    DIR_INIT = 2'd0,
    DIR_LAG  = 2'd1,
    DIR_LEAD = 2'd2
  } dir_e;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_APPLY  = 3'd1,
    SQ_SETTLE = 3'd2,
    SQ_MEAS   = 3'd3,
    SQ_CHECK  = 3'd4
  } seq_e;
endpackage

// File: rtl/pcal_timer.sv
module pcal_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pcal_seq.sv
module pcal_seq
  import pcal_pkg::*;
#(
  parameter int SETTLE_CYC = 200,
  parameter int MEAS_CYC   = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic all_done,
  input  logic any_over,
  output logic apply_en,
  output logic eval_en,
  output logic meter_en,
  output logic busy,
  output logic cal_done,
  output logic cal_fail
);
  localparam int MAXC = (SETTLE_CYC > MEAS_CYC) ? SETTLE_CYC : MEAS_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  seq_e          state;
  logic [TW-1:0] cnt;
  logic          settle_last, meas_last, timing;

  assign timing      = (state == SQ_SETTLE) || (state == SQ_MEAS);
  assign settle_last = (state == SQ_SETTLE) && (cnt == TW'(SETTLE_CYC - 1));
  assign meas_last   = (state == SQ_MEAS)   && (cnt == TW'(MEAS_CYC - 1));

  pcal_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start | settle_last | meas_last | !timing),
    .en    (timing),
    .cnt   (cnt)
  );

  assign apply_en = (state == SQ_APPLY);
  assign eval_en  = meas_last;
  assign meter_en = (state == SQ_MEAS);
  assign busy     = (state != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cal_done <= 1'b0;
      cal_fail <= 1'b0;
    end else if (start) begin
      state    <= SQ_APPLY;
      cal_done <= 1'b0;
      cal_fail <= 1'b0;
    end else begin
      case (state)
        SQ_APPLY:  state <= SQ_SETTLE;
        SQ_SETTLE: if (settle_last) state <= SQ_MEAS;
        SQ_MEAS:   if (meas_last)   state <= SQ_CHECK;
        SQ_CHECK: begin
          if (all_done) begin
            cal_done <= 1'b1;
            state    <= SQ_IDLE;
          end else if (any_over) begin
            cal_fail <= 1'b1;
            state    <= SQ_IDLE;
          end else begin
            state    <= SQ_APPLY;
          end
        end
        default:   state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcal_lane.sv
module pcal_lane
  import pcal_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 5,
  parameter int THRESH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             apply_en,
  input  logic             eval_en,
  input  logic [CNT_W-1:0] ones,
  input  logic [CNT_W-1:0] zeros,
  output logic [DLY_W-1:0] ref_dly,
  output logic [DLY_W-1:0] fb_dly,
  output logic [1:0]       dir,
  output logic             done,
  output logic             over
);
  localparam int DW = CNT_W + 2;
  localparam logic signed [DW-1:0] THR = DW'(THRESH);

  dir_e               dir_q;
  logic [DLY_W:0]     code;
  logic signed [DW-1:0] diff, ndiff;
  logic               lag_big, lead_big;

  assign diff     = $signed({2'b00, ones}) - $signed({2'b00, zeros});
  assign ndiff    = -diff;
  assign lag_big  = diff  > THR;
  assign lead_big = ndiff > THR;

  assign dir  = dir_q;
  assign over = code[DLY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_INIT;
      code    <= '0;
      done    <= 1'b0;
      ref_dly <= '0;
      fb_dly  <= '0;
    end else if (clr) begin
      dir_q   <= DIR_INIT;
      code    <= '0;
      done    <= 1'b0;
      ref_dly <= '0;
      fb_dly  <= '0;
    end else if (!done) begin
      if (apply_en) begin
        case (dir_q)
          DIR_LAG:  begin fb_dly  <= code[DLY_W-1:0]; ref_dly <= '0; end
          DIR_LEAD: begin ref_dly <= code[DLY_W-1:0]; fb_dly  <= '0; end
          default:  begin ref_dly <= '0;              fb_dly  <= '0; end
        endcase
      end
      if (eval_en) begin
        case (dir_q)
          DIR_INIT: begin
            if (lag_big) begin
              dir_q <= DIR_LAG;
              code  <= code + (DLY_W+1)'(1);
            end else if (lead_big) begin
              dir_q <= DIR_LEAD;
              code  <= code + (DLY_W+1)'(1);
            end else begin
              done  <= 1'b1;
            end
          end
          DIR_LAG: begin
            if (!lag_big) done <= 1'b1;
            else          code <= code + (DLY_W+1)'(1);
          end
          DIR_LEAD: begin
            if (!lead_big) done <= 1'b1;
            else           code <= code + (DLY_W+1)'(1);
          end
          default: done <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pll_phase_cal.sv
module pll_phase_cal #(
  parameter int NUM_PLL    = 3,
  parameter int CNT_W      = 16,
  parameter int DLY_W      = 5,
  parameter int THRESH     = 8,
  parameter int SETTLE_CYC = 200,
  parameter int MEAS_CYC   = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NUM_PLL*CNT_W-1:0] ones_cnt,
  input  logic [NUM_PLL*CNT_W-1:0] zeros_cnt,
  output logic                     meter_en,
  output logic [NUM_PLL*DLY_W-1:0] ref_dly,
  output logic [NUM_PLL*DLY_W-1:0] fb_dly,
  output logic [NUM_PLL*2-1:0]     lane_dir,
  output logic [NUM_PLL-1:0]       pll_done,
  output logic                     busy,
  output logic                     cal_done,
  output logic                     cal_fail
);
  logic             apply_en, eval_en;
  logic [NUM_PLL-1:0] lane_over;

  pcal_seq #(
    .SETTLE_CYC (SETTLE_CYC),
    .MEAS_CYC   (MEAS_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .all_done (&pll_done),
    .any_over (|lane_over),
    .apply_en (apply_en),
    .eval_en  (eval_en),
    .meter_en (meter_en),
    .busy     (busy),
    .cal_done (cal_done),
    .cal_fail (cal_fail)
  );

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_lane
    pcal_lane #(
      .CNT_W  (CNT_W),
      .DLY_W  (DLY_W),
      .THRESH (THRESH)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .apply_en (apply_en),
      .eval_en  (eval_en),
      .ones     (ones_cnt[k*CNT_W +: CNT_W]),
      .zeros    (zeros_cnt[k*CNT_W +: CNT_W]),
      .ref_dly  (ref_dly[k*DLY_W +: DLY_W]),
      .fb_dly   (fb_dly[k*DLY_W +: DLY_W]),
      .dir      (lane_dir[k*2 +: 2]),
      .done     (pll_done[k]),
      .over     (lane_over[k])
    );
  end
endmodule

// File: rtl/pll_phase_cal_chk.sv
module pll_phase_cal_chk #(
  parameter int NUM_PLL = 3,
  parameter int DLY_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     meter_en,
  input logic [NUM_PLL*DLY_W-1:0] ref_dly,
  input logic [NUM_PLL*DLY_W-1:0] fb_dly,
  input logic [NUM_PLL-1:0]       pll_done,
  input logic                     busy,
  input logic                     cal_done,
  input logic                     cal_fail
);
  // R8
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done && cal_fail));

  // R8
  all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (&pll_done));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !start) |=> cal_done);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !cal_done && !cal_fail && pll_done == '0));

  // R3
  meter_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meter_en |-> busy);

  // R10
  fields_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meter_en && !start) |=> ($stable(ref_dly) && $stable(fb_dly)));

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_path
    // R10
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_dly[k*DLY_W +: DLY_W] != '0) |-> (fb_dly[k*DLY_W +: DLY_W] == '0));
  end
endmodule

bind pll_phase_cal pll_phase_cal_chk #(
  .NUM_PLL (NUM_PLL),
  .DLY_W   (DLY_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .meter_en (meter_en),
  .ref_dly  (ref_dly),
  .fb_dly   (fb_dly),
  .pll_done (pll_done),
  .busy     (busy),
  .cal_done (cal_done),
  .cal_fail (cal_fail)
);

// File: tb/pll_phase_cal_tb.sv
module pll_phase_cal_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int CW = 16;
  localparam int DW = 5;
  localparam int TH = 8;
  localparam int SC = 4;
  localparam int MC = 8;
  localparam int WIN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NP*CW-1:0] ones_cnt, zeros_cnt;
  logic meter_en, busy, cal_done, cal_fail;
  logic [NP*DW-1:0] ref_dly, fb_dly;
  logic [NP*2-1:0] lane_dir;
  logic [NP-1:0] pll_done;

  int checks = 0;
  int errors = 0;
  int off[NP];
  int gain[NP];
  int exp_ref[NP], exp_fb[NP], exp_dir[NP], exp_dn[NP];
  int exp_rounds, exp_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_phase_cal #(
    .NUM_PLL(NP), .CNT_W(CW), .DLY_W(DW), .THRESH(TH),
    .SETTLE_CYC(SC), .MEAS_CYC(MC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ones_cnt(ones_cnt), .zeros_cnt(zeros_cnt),
    .meter_en(meter_en), .ref_dly(ref_dly), .fb_dly(fb_dly),
    .lane_dir(lane_dir), .pll_done(pll_done), .busy(busy),
    .cal_done(cal_done), .cal_fail(cal_fail)
  );

  function automatic int ones_of(int o, int g, int r, int f);
    int s;
    s = WIN/2 + g * (o + r - f);
    if (s < 0) s = 0;
    if (s > WIN) s = WIN;
    return s;
  endfunction

  // Closed-loop PLL stand-in: counts follow the fields the block drives
  always_comb begin
    for (int k = 0; k < NP; k++) begin
      int on;
      on = ones_of(off[k], gain[k], int'(ref_dly[k*DW +: DW]), int'(fb_dly[k*DW +: DW]));
      ones_cnt[k*CW +: CW]  = CW'(on);
      zeros_cnt[k*CW +: CW] = CW'(WIN - on);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected outcome from the requirement rules
  task automatic model();
    int ph[NP], d[NP], dn[NP], rf[NP], fv[NP];
    for (int k = 0; k < NP; k++) begin ph[k]=0; d[k]=0; dn[k]=0; rf[k]=0; fv[k]=0; end
    exp_rounds = 0; exp_fail = 0;
    for (int it = 0; it < 64; it++) begin
      int alld, anyo;
      exp_rounds++;
      for (int k = 0; k < NP; k++) if (!dn[k]) begin
        if (ph[k]==1) begin fv[k]=d[k]; rf[k]=0; end
        else if (ph[k]==2) begin rf[k]=d[k]; fv[k]=0; end
        else begin rf[k]=0; fv[k]=0; end
      end
      for (int k = 0; k < NP; k++) if (!dn[k]) begin
        int df;
        df = 2*ones_of(off[k], gain[k], rf[k], fv[k]) - WIN;
        if (ph[k]==0) begin
          if (df > TH) begin ph[k]=1; d[k]++; end
          else if (-df > TH) begin ph[k]=2; d[k]++; end
          else dn[k]=1;
        end else if (ph[k]==1) begin
          if (df <= TH) dn[k]=1; else d[k]++;
        end else begin
          if (-df <= TH) dn[k]=1; else d[k]++;
        end
      end
      alld = 1; anyo = 0;
      for (int k = 0; k < NP; k++) begin
        if (!dn[k]) alld = 0;
        if (d[k] >= 32) anyo = 1;
      end
      if (alld) break;
      if (anyo) begin exp_fail = 1; break; end
    end
    for (int k = 0; k < NP; k++) begin
      exp_ref[k]=rf[k]; exp_fb[k]=fv[k]; exp_dir[k]=ph[k]; exp_dn[k]=dn[k];
    end
  endtask

  task automatic run_case(int o0, int o1, int o2, int g0, int g1, int g2, bit restart);
    int n, mc;
    if (restart) begin
      off[0]=-20; off[1]=15; off[2]=9; gain[0]=2; gain[1]=3; gain[2]=2;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (15) @(negedge clk);
    end
    off[0]=o0; off[1]=o1; off[2]=o2; gain[0]=g0; gain[1]=g1; gain[2]=g2;
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2: lanes cleared, busy high after the start edge
    chk(busy === 1'b1 && pll_done === '0 && !cal_done && !cal_fail, "R2", int'(busy), 1);
    n = 0; mc = 0;
    while (n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (meter_en) mc++;
      if (cal_done || cal_fail) break;
    end
    // R3 / R11: round timing counted from this start edge
    chk(n == exp_rounds*(SC+MC+2), restart ? "R11" : "R3", n, exp_rounds*(SC+MC+2));
    chk(mc == exp_rounds*MC, "R3", mc, exp_rounds*MC);
    chk(int'(cal_fail) == exp_fail, "R9", int'(cal_fail), exp_fail);
    chk(int'(cal_done) == (1 - exp_fail), "R8", int'(cal_done), 1 - exp_fail);
    chk(busy == 1'b0, "R8", int'(busy), 0);
    for (int k = 0; k < NP; k++) begin
      // R4 R5 R6 R7: final fields, direction and done per lane
      chk(int'(lane_dir[k*2 +: 2]) == exp_dir[k], "R4", int'(lane_dir[k*2 +: 2]), exp_dir[k]);
      chk(int'(ref_dly[k*DW +: DW]) == exp_ref[k], "R6", int'(ref_dly[k*DW +: DW]), exp_ref[k]);
      chk(int'(fb_dly[k*DW +: DW]) == exp_fb[k], "R5", int'(fb_dly[k*DW +: DW]), exp_fb[k]);
      chk(int'(pll_done[k]) == exp_dn[k], "R7", int'(pll_done[k]), exp_dn[k]);
    end
    repeat (10) @(negedge clk);
    chk(int'(cal_done) == (1 - exp_fail), "R8", int'(cal_done), 1 - exp_fail);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    summary();
  end

  initial begin
    for (int k = 0; k < NP; k++) begin off[k] = 0; gain[k] = 1; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !meter_en && !cal_done && !cal_fail, "R1", int'(busy), 0);
    chk(ref_dly == '0 && fb_dly == '0 && lane_dir == '0 && pll_done == '0, "R1",
        int'(ref_dly), 0);

    // R4: in phase and exactly on the threshold (D = 8, -8)
    run_case(0, 1, -1, 4, 4, 4, 1'b0);
    // R4 R6: one step past threshold leads (D = -10)
    run_case(-1, 0, 2, 5, 4, 5, 1'b0);
    // R5 R7: lanes finishing in different rounds
    run_case(3, -5, 12, 4, 4, 2, 1'b0);
    // R9: overflow of one lane
    run_case(40, 0, -3, 1, 4, 3, 1'b0);
    // R9: reference path overflow
    run_case(0, -45, 0, 4, 2, 4, 1'b0);
    // R11: restart mid-run
    run_case(6, -7, 2, 3, 3, 6, 1'b1);
    for (int i = 0; i < 8; i++) begin
      int o[NP], g[NP];
      for (int k = 0; k < NP; k++) begin
        o[k] = int'($urandom_range(0, 76)) - 38;
        g[k] = int'($urandom_range(1, 12));
      end
      run_case(o[0], o[1], o[2], g[0], g[1], g[2], 1'b0);
    end
    summary();
  end
endmodule